// File: doc/BRIEF.md
# Graphics Command Packet Parser

This block sits at the front of a graphics engine. It takes a stream of 32-bit command words and cuts it into whole packets. The opcode of a packet sits in the top byte of its first word, and an opcode-indexed length decode gives the number of parameter words that follow it. A packet is held in an internal store until its last word has arrived, and only then does it leave, word by word, on a valid/ready stream to the renderer.

While the words arrive, the parser keeps some shadow state up to date:

- **Environment registers.** State-setting opcodes are stored into a bank of eight environment registers.
- **Texture page.** Textured primitives update the texture-page field of environment register 1.
- **Dirty flag.** Drawing and transfer opcodes raise a sticky frame-buffer-dirty flag.
- **Status bits.** A short status field is refreshed from the environment bank after each packet.

Image-transfer opcodes are not sent to the renderer. A write-to-memory command announces a rectangle to the transfer engine. The pixel words that follow it are then routed to a separate pixel stream until the rectangle is filled. A read-from-memory command only announces its rectangle.

**Back-pressure rules.**

- Input is accepted (`in_ready` high) only while the parser is collecting a packet, or, during a pixel phase, while `pix_ready` is high.
- While a packet drains, `in_ready` stays low. The output word and its last flag stay stable until `out_ready` takes them.

Top module: `gfx_pkt_parser`

## Requirements
- R1: The opcode is `in_data[31:24]` of a packet's first word. The packet is 1 + N words long, where N is the extra-word count below. The packet is sent on `out_data` in arrival order, and `out_last` is set on its final word only. Extra-word counts:
  - 0x02 → 2
  - 0x20–23 → 3
  - 0x24–27 → 6
  - 0x28–2B → 4
  - 0x2C–2F → 8
  - 0x30–33 → 5
  - 0x34–37 → 8
  - 0x38–3B → 7
  - 0x3C–3F → 11
  - 0x40–43 → 2
  - 0x48–4F → 3
  - 0x50–53 → 3
  - 0x58–5F → 4
  - 0x60–63 → 2
  - 0x64–67 → 3
  - 0x68–6B → 1
  - 0x6C–6F → 2
  - 0x70–73 → 1
  - 0x74–77 → 2
  - 0x78–7B → 1
  - 0x7C–7F → 2
  - 0x80 → 3
  - 0xA0 → 2
  - 0xC0 → 2
  - every other opcode → 0, which makes a one-word packet
- R2: No word of a packet appears on the output before its last word has been accepted. `in_ready` is low whenever `out_valid` is high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R4: An opcode with `op & 0xF8 == 0xE0` stores its whole word into environment register `op[2:0]`. The register is readable on `env_q` when `env_sel` selects it.
- R5: For `op & 0xF4 == 0x24`, bits 8:0 of word 4 (the first word is word 0) replace bits 8:0 of environment register 1. For `op & 0xF4 == 0x34`, bits 8:0 of word 5 are used instead.
- R6: Opcodes 0xA0 and 0xC0 are never sent on the output. When their third word is accepted, `xfer_start` pulses for one cycle. With it come the transfer fields:
  - `xfer_x` = word1[9:0]
  - `xfer_y` = word1[24:16]
  - `xfer_w` = word2[9:0]
  - `xfer_h` = word2[24:16]
  - `xfer_read` = 1 for 0xC0 and 0 for 0xA0
- R7: After 0xA0, the next ceil(w·h/2) input words go to `pix_data` in order, with `pix_last` on the final one, and are not parsed. Parsing then resumes. After 0xC0, or after a zero-size 0xA0, parsing resumes at once.
- R8: An opcode in 0x02..0xBF sets `fb_dirty`. The flag stays set until a `dirty_clr` pulse clears it. Opcodes outside that range leave it unchanged.
- R9: One cycle after a packet's last word is accepted, `status_lo` becomes {env6[1:0], env1[10:0]}. `status_lo` does not change at any other time.
- R10: After reset:
  - `in_ready` = 1
  - `out_valid`, `pix_valid`, `xfer_start`, `fb_dirty` = 0
  - `status_lo` = 0
  - every environment register = 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command or pixel word |
| in_ready | output | 1 | Parser accepts `in_data` |
| out_valid | output | 1 | Packet word valid |
| out_data | output | 32 | Packet word to renderer |
| out_last | output | 1 | Final word of the packet |
| out_ready | input | 1 | Renderer takes the word |
| xfer_start | output | 1 | One-cycle rectangle transfer start |
| xfer_read | output | 1 | 1 = read from memory, 0 = write |
| xfer_x | output | 10 | Rectangle left edge |
| xfer_y | output | 9 | Rectangle top edge |
| xfer_w | output | 10 | Rectangle width |
| xfer_h | output | 9 | Rectangle height |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word (two pixels) |
| pix_last | output | 1 | Final pixel word of the rectangle |
| pix_ready | input | 1 | Transfer engine takes the pixel word |
| env_sel | input | 3 | Environment register select |
| env_q | output | 32 | Selected environment register |
| status_lo | output | 13 | Status field from environment bank |
| fb_dirty | output | 1 | Sticky frame-buffer-dirty flag |
| dirty_clr | input | 1 | Clears `fb_dirty` |

## Verification
The assertions check the following on every cycle:

- Output stability under back-pressure.
- The exclusion between draining a packet and accepting input.
- That a transfer start never coincides with a packet word.
- That the dirty flag stays set without a clear.
- That the pixel path goes quiet after its last word.
- That the status field moves only on a packet-done update.

Only the bench's scenarios can show the rest:

- Packet lengths and word order for each opcode family.
- Which parameter word feeds the texture page.
- The transfer fields and the pixel word count for a given rectangle.
- The status value produced by a given sequence of environment writes.

// File: rtl/gpp_pkg.sv
package gpp_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int LEN_W  = 4;

  typedef enum logic [1:0] {ST_COLLECT, ST_DRAIN, ST_PIXEL} gpp_state_e;

  function automatic logic [LEN_W-1:0] extra_words(input logic [OP_W-1:0] op);
    logic [LEN_W-1:0] n;
    case (op) inside
      8'h02:           n = 4'd2;
      [8'h20:8'h23]:   n = 4'd3;
      [8'h24:8'h27]:   n = 4'd6;
      [8'h28:8'h2B]:   n = 4'd4;
      [8'h2C:8'h2F]:   n = 4'd8;
      [8'h30:8'h33]:   n = 4'd5;
      [8'h34:8'h37]:   n = 4'd8;
      [8'h38:8'h3B]:   n = 4'd7;
      [8'h3C:8'h3F]:   n = 4'd11;
      [8'h40:8'h43]:   n = 4'd2;
      [8'h48:8'h4F]:   n = 4'd3;
      [8'h50:8'h53]:   n = 4'd3;
      [8'h58:8'h5F]:   n = 4'd4;
      [8'h60:8'h63]:   n = 4'd2;
      [8'h64:8'h67]:   n = 4'd3;
      [8'h68:8'h6B]:   n = 4'd1;
      [8'h6C:8'h6F]:   n = 4'd2;
      [8'h70:8'h73]:   n = 4'd1;
      [8'h74:8'h77]:   n = 4'd2;
      [8'h78:8'h7B]:   n = 4'd1;
      [8'h7C:8'h7F]:   n = 4'd2;
      8'h80:           n = 4'd3;
      8'hA0:           n = 4'd2;
      8'hC0:           n = 4'd2;
      default:         n = 4'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/gpp_op_decode.sv
module gpp_op_decode
  import gpp_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  output logic [LEN_W-1:0] pkt_len,
  output logic             is_env,
  output logic             is_tex_flat,
  output logic             is_tex_shaded,
  output logic             is_img_wr,
  output logic             is_img_rd,
  output logic             marks_dirty
);
  always_comb begin
    pkt_len       = extra_words(op) + LEN_W'(1);
    is_env        = (op & 8'hF8) == 8'hE0;
    is_tex_flat   = (op & 8'hF4) == 8'h24;
    is_tex_shaded = (op & 8'hF4) == 8'h34;
    is_img_wr     = op == 8'hA0;
    is_img_rd     = op == 8'hC0;
    marks_dirty   = (op >= 8'h02) && (op < 8'hC0);
  end
endmodule

// File: rtl/gpp_env_bank.sv
module gpp_env_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_ENV  = 8,
  parameter int TP_W     = 9,
  parameter int TP_REG   = 1,
  parameter int ST_REG   = 6,
  parameter int ST_LO_W  = 11,
  parameter int ST_HI_W  = 2,
  localparam int IDX_W   = $clog2(NUM_ENV),
  localparam int STAT_W  = ST_LO_W + ST_HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              env_we,
  input  logic [IDX_W-1:0]  env_idx,
  input  logic [DATA_W-1:0] env_wdata,
  input  logic              tp_we,
  input  logic [TP_W-1:0]   tp_data,
  input  logic              stat_upd,
  input  logic [IDX_W-1:0]  env_sel,
  output logic [DATA_W-1:0] env_q,
  output logic [STAT_W-1:0] status_lo
);
  logic [NUM_ENV-1:0][DATA_W-1:0] env_vec;

  for (genvar i = 0; i < NUM_ENV; i++) begin : g_env
    logic [DATA_W-1:0] r;
    if (i == TP_REG) begin : g_tp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                r <= '0;
        else if (env_we && env_idx == IDX_W'(i))   r <= env_wdata;
        else if (tp_we)                            r[TP_W-1:0] <= tp_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                r <= '0;
        else if (env_we && env_idx == IDX_W'(i))   r <= env_wdata;
      end
    end
    assign env_vec[i] = r;
  end

  assign env_q = env_vec[env_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_lo <= '0;
    else if (stat_upd) status_lo <= {env_vec[ST_REG][ST_HI_W-1:0], env_vec[TP_REG][ST_LO_W-1:0]};
  end

  // R9: status moves only on a packet-done update
  assert_status_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_upd |=> $stable(status_lo));
endmodule

// File: rtl/gpp_pkt_store.sv
module gpp_pkt_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 12,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0][DATA_W-1:0] mem;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i)) r <= wr_data;
    end
    assign mem[i] = r;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rd_idx == IDX_W'(k)) rd_data = mem[k];
  end
endmodule

// File: rtl/gfx_pkt_parser.sv
module gfx_pkt_parser
  import gpp_pkg::*;
#(
  parameter int MAX_WORDS = 12,
  parameter int NUM_ENV   = 8,
  parameter int X_W       = 10,
  parameter int Y_W       = 9,
  parameter int TP_W      = 9,
  localparam int IDX_W    = $clog2(MAX_WORDS + 1),
  localparam int ESEL_W   = $clog2(NUM_ENV),
  localparam int PIX_W    = X_W + Y_W,
  localparam int STAT_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              xfer_start,
  output logic              xfer_read,
  output logic [X_W-1:0]    xfer_x,
  output logic [Y_W-1:0]    xfer_y,
  output logic [X_W-1:0]    xfer_w,
  output logic [Y_W-1:0]    xfer_h,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pix_data,
  output logic              pix_last,
  input  logic              pix_ready,
  input  logic [ESEL_W-1:0] env_sel,
  output logic [WORD_W-1:0] env_q,
  output logic [STAT_W-1:0] status_lo,
  output logic              fb_dirty,
  input  logic              dirty_clr
);
  gpp_state_e        state;
  logic [IDX_W-1:0]  idx, rd_idx;
  logic [LEN_W-1:0]  len_q;
  logic [OP_W-1:0]   op_q, op_sel;
  logic [X_W-1:0]    pos_x_q;
  logic [Y_W-1:0]    pos_y_q;
  logic [PIX_W-1:0]  pix_left;
  logic              pkt_done_q;
  logic [WORD_W-1:0] rd_data;

  logic [LEN_W-1:0]  len_sel;
  logic is_env, is_tf, is_ts, is_wr, is_rd, dirty_op;

  logic acc, last_in, first_in;
  logic [X_W-1:0]    sz_w;
  logic [Y_W-1:0]    sz_h;
  logic [PIX_W:0]    px_total;
  logic [PIX_W-1:0]  px_words;

  assign first_in = (idx == '0);
  assign op_sel   = first_in ? in_data[31:24] : op_q;

  gpp_op_decode u_dec (
    .op(op_sel), .pkt_len(len_sel), .is_env(is_env), .is_tex_flat(is_tf),
    .is_tex_shaded(is_ts), .is_img_wr(is_wr), .is_img_rd(is_rd), .marks_dirty(dirty_op)
  );

  assign acc      = in_valid && in_ready;
  assign last_in  = (idx == IDX_W'(len_sel - LEN_W'(1)));
  assign sz_w     = in_data[X_W-1:0];
  assign sz_h     = in_data[16 +: Y_W];
  assign px_total = (PIX_W+1)'(sz_w * sz_h) + (PIX_W+1)'(1);
  assign px_words = px_total[PIX_W:1];

  always_comb begin
    in_ready = 1'b0;
    case (state)
      ST_COLLECT: in_ready = 1'b1;
      ST_PIXEL:   in_ready = pix_ready;
      default:    in_ready = 1'b0;
    endcase
  end

  assign out_valid = (state == ST_DRAIN);
  assign out_data  = rd_data;
  assign out_last  = out_valid && (rd_idx == IDX_W'(len_q - LEN_W'(1)));
  assign pix_valid = (state == ST_PIXEL) && in_valid;
  assign pix_data  = in_data;
  assign pix_last  = pix_valid && (pix_left == PIX_W'(1));

  gpp_pkt_store #(.DATA_W(WORD_W), .DEPTH(MAX_WORDS)) u_store (
    .clk(clk), .wr_en(acc && state == ST_COLLECT), .wr_idx(idx), .wr_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  gpp_env_bank #(.DATA_W(WORD_W), .NUM_ENV(NUM_ENV), .TP_W(TP_W)) u_env (
    .clk(clk), .rst_n(rst_n),
    .env_we(acc && state == ST_COLLECT && first_in && is_env),
    .env_idx(in_data[24 +: ESEL_W]), .env_wdata(in_data),
    .tp_we(acc && state == ST_COLLECT &&
           ((is_tf && idx == IDX_W'(4)) || (is_ts && idx == IDX_W'(5)))),
    .tp_data(in_data[TP_W-1:0]),
    .stat_upd(pkt_done_q), .env_sel(env_sel), .env_q(env_q), .status_lo(status_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT; idx <= '0; rd_idx <= '0; len_q <= '0; op_q <= '0;
      pos_x_q <= '0; pos_y_q <= '0; pix_left <= '0; pkt_done_q <= 1'b0;
      xfer_start <= 1'b0; xfer_read <= 1'b0; xfer_x <= '0; xfer_y <= '0;
      xfer_w <= '0; xfer_h <= '0; fb_dirty <= 1'b0;
    end else begin
      pkt_done_q <= 1'b0;
      xfer_start <= 1'b0;
      if (acc && state == ST_COLLECT && first_in && dirty_op) fb_dirty <= 1'b1;
      else if (dirty_clr)                                     fb_dirty <= 1'b0;
      case (state)
        ST_COLLECT: if (acc) begin
          if (first_in) begin
            op_q  <= in_data[31:24];
            len_q <= len_sel;
          end
          if ((is_wr || is_rd) && idx == IDX_W'(1)) begin
            pos_x_q <= in_data[X_W-1:0];
            pos_y_q <= in_data[16 +: Y_W];
          end
          if (last_in) begin
            idx        <= '0;
            pkt_done_q <= 1'b1;
            if (is_wr || is_rd) begin
              xfer_start <= 1'b1;
              xfer_read  <= is_rd;
              xfer_x <= pos_x_q; xfer_y <= pos_y_q; xfer_w <= sz_w; xfer_h <= sz_h;
              if (is_wr && px_words != '0) begin
                pix_left <= px_words;
                state    <= ST_PIXEL;
              end
            end else begin
              rd_idx <= '0;
              state  <= ST_DRAIN;
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_DRAIN: if (out_ready) begin
          if (out_last) state <= ST_COLLECT;
          else          rd_idx <= rd_idx + IDX_W'(1);
        end
        ST_PIXEL: if (acc) begin
          pix_left <= pix_left - PIX_W'(1);
          if (pix_left == PIX_W'(1)) state <= ST_COLLECT;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // R3: output held while stalled
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R2: no input accepted while a packet drains
  assert_no_accept_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R6: transfer start never shares a cycle with a packet word
  assert_xfer_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !out_valid);
  // R8: dirty flag is sticky until cleared
  assert_dirty_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_dirty && !dirty_clr |=> fb_dirty);
  // R7: pixel path goes quiet after its last word
  assert_pix_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last |=> !pix_valid);
endmodule

// File: tb/tb_gfx_pkt_parser.sv
`timescale 1ns/1ps
module tb_gfx_pkt_parser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, pix_ready = 1'b1, dirty_clr = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  env_sel = '0;
  logic in_ready, out_valid, out_last, xfer_start, xfer_read, pix_valid, pix_last, fb_dirty;
  logic [31:0] out_data, pix_data, env_q;
  logic [9:0]  xfer_x, xfer_w;
  logic [8:0]  xfer_y, xfer_h;
  logic [12:0] status_lo;

  always #2.5 clk = ~clk;

  gfx_pkt_parser dut (.*);

  int checks = 0, errors = 0;
  int rdy_mode = 0;
  logic tog = 1'b0;
  logic [32:0] exp_out[$];
  logic [32:0] exp_pix[$];
  logic [38:0] exp_xfer[$];
  logic [31:0] pw [0:15];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    tog = ~tog;
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? tog : 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      if (exp_out.size() == 0) chk(0, "R1 unexpected packet word", {31'b0, out_last, out_data}, 0);
      else begin
        logic [32:0] e;
        e = exp_out.pop_front();
        chk({out_last, out_data} == e, "R1 packet word/last", {31'b0, out_last, out_data}, {31'b0, e});
      end
    end
    if (pix_valid && pix_ready) begin
      if (exp_pix.size() == 0) chk(0, "R7 unexpected pixel word", {32'b0, pix_data}, 0);
      else begin
        logic [32:0] e;
        e = exp_pix.pop_front();
        chk({pix_last, pix_data} == e, "R7 pixel word/last", {31'b0, pix_last, pix_data}, {31'b0, e});
      end
    end
    if (xfer_start) begin
      if (exp_xfer.size() == 0) chk(0, "R6 unexpected transfer start", 0, 0);
      else begin
        logic [38:0] e;
        e = exp_xfer.pop_front();
        chk({xfer_read, xfer_x, xfer_y, xfer_w, xfer_h} == e, "R6 transfer fields",
            {25'b0, xfer_read, xfer_x, xfer_y, xfer_w, xfer_h}, {25'b0, e});
      end
    end
  end

  task automatic send(input logic [31:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // sends pw[lo..hi-1]; expects them on the output when emit is set
  task automatic send_range(input int lo, input int hi, input int total, input bit emit);
    for (int i = lo; i < hi; i++) begin
      if (emit) exp_out.push_back({(i == total - 1), pw[i]});
      send(pw[i]);
    end
  endtask

  task automatic pkt(input int n);
    send_range(0, n, n, 1'b1);
  endtask

  task automatic settle();
    int guard = 0;
    while ((exp_out.size() != 0 || exp_pix.size() != 0 || exp_xfer.size() != 0 || out_valid) && guard < 200) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_env(input int sel, input logic [31:0] v, input string req);
    env_sel = sel[2:0];
    @(negedge clk);
    chk(env_q == v, req, {32'b0, env_q}, {32'b0, v});
  endtask

  task automatic clear_dirty();
    @(posedge clk); #1; dirty_clr = 1'b1;
    @(posedge clk); #1; dirty_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10 in_ready", {63'b0, in_ready}, 1);
    chk(out_valid == 1'b0 && pix_valid == 1'b0 && xfer_start == 1'b0, "R10 outputs idle", {61'b0, out_valid, pix_valid, xfer_start}, 0);
    chk(fb_dirty == 1'b0, "R10 dirty", {63'b0, fb_dirty}, 0);
    chk(status_lo == 13'h0, "R10 status", {51'b0, status_lo}, 0);
    check_env(1, 32'h0, "R10 env1");

    // R1 zero-entry opcodes are one-word packets; R8 they leave dirty clear
    pw[0] = 32'h0012_3456; pkt(1);
    pw[0] = 32'h01AB_CDEF; pkt(1);
    // R4 environment writes
    pw[0] = 32'hE100_0123; pkt(1);
    pw[0] = 32'hE600_0002; pkt(1);
    settle();
    chk(fb_dirty == 1'b0, "R8 no dirty for 0x00/0x01/0xE1/0xE6", {63'b0, fb_dirty}, 0);
    check_env(1, 32'hE100_0123, "R4 env1");
    check_env(6, 32'hE600_0002, "R4 env6");
    // R9 status = {env6[1:0], env1[10:0]}
    chk(status_lo == 13'h1123, "R9 status after env writes", {51'b0, status_lo}, 13'h1123);

    // R1 four-word packet 0x20, R8 dirty set
    for (int i = 0; i < 4; i++) pw[i] = 32'h2000_0000 + i;
    pkt(4);
    settle();
    chk(fb_dirty == 1'b1, "R8 dirty after 0x20", {63'b0, fb_dirty}, 1);
    clear_dirty();
    @(negedge clk);
    chk(fb_dirty == 1'b0, "R8 dirty cleared", {63'b0, fb_dirty}, 0);

    // R5 flat textured: word 4 feeds texture page
    for (int i = 0; i < 7; i++) pw[i] = 32'h2400_0000 + 32'(i);
    pw[4] = 32'h0000_F1AB;
    pkt(7);
    settle();
    check_env(1, 32'hE100_01AB, "R5 flat tex page from word4");
    chk(status_lo == 13'h11AB, "R9 status after flat tex", {51'b0, status_lo}, 13'h11AB);

    // R5 shaded textured: word 5 used, not word 4
    for (int i = 0; i < 9; i++) pw[i] = 32'h3400_0000 + 32'(i);
    pw[4] = 32'h0000_01FF; pw[5] = 32'h0000_00FF;
    pkt(9);
    settle();
    check_env(1, 32'hE100_00FF, "R5 shaded tex page from word5");

    // R1/R3 twelve-word packet under toggling back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 12; i++) pw[i] = 32'h3C00_0100 + 32'(i);
    pkt(12);
    settle();
    rdy_mode = 0;

    // R2 partial packet held
    for (int i = 0; i < 5; i++) pw[i] = 32'h2800_0200 + 32'(i);
    send_range(0, 3, 5, 1'b1);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R2 partial packet not emitted", {63'b0, out_valid}, 0);
    send_range(3, 5, 5, 1'b1);
    settle();

    // R2/R3 held ready low
    rdy_mode = 2;
    for (int i = 0; i < 3; i++) pw[i] = 32'h6000_0300 + 32'(i);
    pkt(3);
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R2 stalled drain blocks input", {62'b0, out_valid, in_ready}, 2);
    chk(out_data == 32'h6000_0300, "R3 first word held", {32'b0, out_data}, 32'h6000_0300);
    rdy_mode = 0;
    settle();

    // R6/R7 write transfer 3x3 -> 5 pixel words
    clear_dirty();
    exp_xfer.push_back({1'b0, 10'd3, 9'd5, 10'd3, 9'd3});
    pw[0] = 32'hA000_0000; pw[1] = 32'h0005_0003; pw[2] = 32'h0003_0003;
    send_range(0, 3, 3, 1'b0);
    for (int i = 0; i < 5; i++) begin
      exp_pix.push_back({(i == 4), 32'hCAFE_0000 + 32'(i)});
      send(32'hCAFE_0000 + 32'(i));
    end
    pw[0] = 32'h0300_0001; pkt(1);
    settle();
    chk(fb_dirty == 1'b1, "R8 dirty after 0xA0", {63'b0, fb_dirty}, 1);

    // R6/R7 read transfer, parsing resumes immediately; R8 0xC0 not dirty
    clear_dirty();
    exp_xfer.push_back({1'b1, 10'd2, 9'd1, 10'd4, 9'd2});
    pw[0] = 32'hC000_0000; pw[1] = 32'h0001_0002; pw[2] = 32'h0002_0004;
    send_range(0, 3, 3, 1'b0);
    pw[0] = 32'h01FF_0000; pkt(1);
    settle();
    chk(fb_dirty == 1'b0, "R8 0xC0 leaves dirty clear", {63'b0, fb_dirty}, 0);

    // R1 0x80 four-word packet
    for (int i = 0; i < 4; i++) pw[i] = 32'h8000_0400 + 32'(i);
    pkt(4);
    settle();
    chk(fb_dirty == 1'b1, "R8 dirty after 0x80", {63'b0, fb_dirty}, 1);
    chk(exp_out.size() == 0 && exp_pix.size() == 0 && exp_xfer.size() == 0, "R1 scoreboard drained",
        64'(exp_out.size() + exp_pix.size() + exp_xfer.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule